// File: doc/BRIEF.md
# Card Clock Divider with Update Handshake

This block derives a card clock from its reference clock through a programmable even divider and a run/stop enable. Software programs a divisor, an enable and a clock-source selection through a small register port. Those writes do not touch the running clock. They sit in pending registers until software writes a command word that has both the start flag and the clock-update flag set.

The start flag reads back as 1 until hardware loads the pending settings into the generator. Hardware then clears it, so software polls it to know when the switch is done. A change is loaded only while the divided clock is low, which means no shortened high pulse is ever produced. An update may be told to wait for an ongoing data transfer. A command written while a previous one is still being taken in is discarded, and it raises a sticky locked-command error flag that is cleared by writing 1 to it.

Register map (byte offsets): divisor at 0x00 (bits 7:0), enable at 0x04 (bit 0), source select at 0x08 (bits 1:0), command at 0x0C, raw status at 0x10.

Top module: `card_clk_div`

## Requirements
- R1: After reset, card_clk_o is 0, card_src_o is 0, and reads of the command and raw status registers return 0.
- R2: With an applied divisor N in 1..255 and the enable at 1, card_clk_o has a period of 2N reference cycles, high for N and low for N.
- R3: With an applied divisor of 0 and the enable at 1, card_clk_o follows the reference clock.
- R4: Writes to the divisor, enable or source registers read back at once, but card_clk_o and card_src_o keep their old settings until an update is committed.
- R5: A command write with bit 31 (start) and bit 21 (clock update) set makes command bit 31 read 1. Bit 31 returns to 0 on the clock edge that loads the pending settings.
- R6: Pending settings are loaded only while the divided clock is low. A stopped clock (enable 0) stays low, and every high phase lasts its full N cycles.
- R7: A command write with bit 31 set while the start flag is still 1 sets raw status bit 12. That command is discarded, and its flags do not replace those of the command in progress.
- R8: Writing 1 to raw status bit 12 clears it. Writing 0 leaves it unchanged.
- R9: An update with bit 13 (wait for data) set is not loaded while data_busy_i is 1. Without bit 13, data_busy_i has no effect.
- R10: A command write with bit 31 set but bit 21 clear is not accepted: the start flag stays 0 and nothing pending is loaded.
- R11: The source selection reaches card_src_o through the same update as the divisor and enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte address for reads and writes |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| data_busy_i | input | 1 | A data transfer is in progress |
| card_clk_o | output | 1 | Divided card clock |
| card_src_o | output | 2 | Applied clock-source selection |

## Verification
The bench goes after an enable switched off in the middle of a high phase. A design that commits at once would cut that pulse short, which the per-cycle model comparison sees as an early falling edge. It also sends a second command while an update is held back by data_busy_i. A design that accepted the second command, or took its wait flag, would commit early and clear the start flag, and a design without the sticky error flag would read bit 12 as 0. A command lacking the update flag, a write of 0 to the error flag, and divisor 0 bypass are each checked at the ports. A divider off by one would show up as a wrong rising-edge spacing.

// File: rtl/card_clk_div_pkg.sv
package card_clk_div_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_DIV = 8'h00;
  localparam logic [ADDR_W-1:0] A_EN  = 8'h04;
  localparam logic [ADDR_W-1:0] A_SRC = 8'h08;
  localparam logic [ADDR_W-1:0] A_CMD = 8'h0C;
  localparam logic [ADDR_W-1:0] A_RAW = 8'h10;

  localparam int unsigned B_START = 31;
  localparam int unsigned B_UPD   = 21;
  localparam int unsigned B_WAIT  = 13;
  localparam int unsigned B_LOCK  = 12;

  typedef struct packed {
    logic start;
    logic upd;
    logic wait_data;
  } cmd_fields_t;
endpackage

// File: rtl/ckdiv_regs.sv
module ckdiv_regs
  import card_clk_div_pkg::*;
#(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned SRC_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              start_i,
  input  logic              lock_set_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DIV_W-1:0]  div_pend_o,
  output logic              en_pend_o,
  output logic [SRC_W-1:0]  src_pend_o,
  output logic              cmd_wr_o,
  output cmd_fields_t       cmd_o,
  output logic              lock_err_o
);
  logic [DIV_W-1:0] div_q;
  logic             en_q;
  logic [SRC_W-1:0] src_q;
  logic             err_q;
  logic             raw_wr;

  assign cmd_wr_o = wr_en_i && (addr_i == A_CMD);
  assign raw_wr   = wr_en_i && (addr_i == A_RAW);
  assign cmd_o    = '{start: wdata_i[B_START], upd: wdata_i[B_UPD],
                      wait_data: wdata_i[B_WAIT]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      en_q  <= 1'b0;
      src_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (wr_en_i && addr_i == A_DIV) div_q <= wdata_i[DIV_W-1:0];
      if (wr_en_i && addr_i == A_EN)  en_q  <= wdata_i[0];
      if (wr_en_i && addr_i == A_SRC) src_q <= wdata_i[SRC_W-1:0];
      if (lock_set_i)                        err_q <= 1'b1;
      else if (raw_wr && wdata_i[B_LOCK])    err_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_DIV: rdata_o[DIV_W-1:0] = div_q;
      A_EN:  rdata_o[0]         = en_q;
      A_SRC: rdata_o[SRC_W-1:0] = src_q;
      A_CMD: rdata_o[B_START]   = start_i;
      A_RAW: rdata_o[B_LOCK]    = err_q;
      default: rdata_o = '0;
    endcase
  end

  assign div_pend_o = div_q;
  assign en_pend_o  = en_q;
  assign src_pend_o = src_q;
  assign lock_err_o = err_q;

  // R8: writing 0 never clears the flag
  assert_zero_write_keeps_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && raw_wr && !wdata_i[B_LOCK]) |=> err_q);
endmodule

// File: rtl/ckdiv_update_ctrl.sv
module ckdiv_update_ctrl
  import card_clk_div_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_wr_i,
  input  cmd_fields_t cmd_i,
  input  logic        data_busy_i,
  input  logic        phase_low_i,
  output logic        start_o,
  output logic        commit_o,
  output logic        lock_set_o
);
  logic start_q, wait_q, accept;

  assign lock_set_o = cmd_wr_i && cmd_i.start && start_q;
  assign accept     = cmd_wr_i && cmd_i.start && cmd_i.upd && !start_q;
  assign commit_o   = start_q && phase_low_i && !(wait_q && data_busy_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      wait_q  <= 1'b0;
    end else if (accept) begin
      start_q <= 1'b1;
      wait_q  <= cmd_i.wait_data;
    end else if (commit_o) begin
      start_q <= 1'b0;
    end
  end

  assign start_o = start_q;

  assert_commit_clears_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !start_q);
  assert_locked_cmd_discarded_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_set_o && !commit_o) |=> (start_q && $stable(wait_q)));
  assert_no_start_without_update_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && cmd_i.start && !cmd_i.upd && !start_q) |=> !start_q);
  assert_busy_defers_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_q && wait_q && data_busy_i) |=> start_q);
endmodule

// File: rtl/ckdiv_gen.sv
module ckdiv_gen #(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned SRC_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             commit_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             en_i,
  input  logic [SRC_W-1:0] src_i,
  output logic             phase_low_o,
  output logic             card_clk_o,
  output logic [SRC_W-1:0] src_o
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] div_q, cnt_q;
  logic             en_q, tog_q, bypass;
  logic [SRC_W-1:0] src_q;

  assign bypass = (div_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      en_q  <= 1'b0;
      src_q <= '0;
      cnt_q <= '0;
      tog_q <= 1'b0;
    end else if (commit_i) begin
      div_q <= div_i;
      en_q  <= en_i;
      src_q <= src_i;
      cnt_q <= '0;
      tog_q <= 1'b0;
    end else if (en_q && !bypass) begin
      if (cnt_q == div_q - ONE) begin
        cnt_q <= '0;
        tog_q <= ~tog_q;
      end else begin
        cnt_q <= cnt_q + ONE;
      end
    end
  end

  // bypass gates the reference directly; a commit only occurs with tog_q low
  assign card_clk_o  = bypass ? (clk_i & en_q) : tog_q;
  assign phase_low_o = !tog_q;
  assign src_o       = src_q;

  assert_commit_low_phase_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> !tog_q);
  assert_stopped_stays_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !commit_i) |=> !tog_q);
  assert_half_period_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit_i && en_q && !bypass && cnt_q != div_q - ONE) |=> $stable(tog_q));
endmodule

// File: rtl/card_clk_div.sv
module card_clk_div
  import card_clk_div_pkg::*;
#(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned SRC_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              data_busy_i,
  output logic              card_clk_o,
  output logic [SRC_W-1:0]  card_src_o
);
  logic [DIV_W-1:0] div_pend;
  logic             en_pend;
  logic [SRC_W-1:0] src_pend;
  logic             cmd_wr, start, commit, lock_set, lock_err, phase_low;
  cmd_fields_t      cmd;

  ckdiv_regs #(.DIV_W(DIV_W), .SRC_W(SRC_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .start_i(start), .lock_set_i(lock_set), .rdata_o,
    .div_pend_o(div_pend), .en_pend_o(en_pend), .src_pend_o(src_pend),
    .cmd_wr_o(cmd_wr), .cmd_o(cmd), .lock_err_o(lock_err)
  );

  ckdiv_update_ctrl u_ctrl (
    .clk_i, .rst_ni, .cmd_wr_i(cmd_wr), .cmd_i(cmd), .data_busy_i,
    .phase_low_i(phase_low), .start_o(start), .commit_o(commit),
    .lock_set_o(lock_set)
  );

  ckdiv_gen #(.DIV_W(DIV_W), .SRC_W(SRC_W)) u_gen (
    .clk_i, .rst_ni, .commit_i(commit), .div_i(div_pend), .en_i(en_pend),
    .src_i(src_pend), .phase_low_o(phase_low), .card_clk_o,
    .src_o(card_src_o)
  );

  assert_lock_flag_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_CMD && wdata_i[B_START] && start) |=> lock_err);
  assert_src_only_on_commit_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> $stable(card_src_o));
endmodule

// File: tb/card_clk_div_test.sv
`timescale 1ns/1ps
module card_clk_div_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  addr_i = 8'h00;
  logic [31:0] wdata_i = '0;
  logic        data_busy_i = 1'b0;
  logic [31:0] rdata_o;
  logic        card_clk_o;
  logic [1:0]  card_src_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  localparam logic [31:0] UPD      = 32'h8020_0000;
  localparam logic [31:0] UPD_WAIT = 32'h8020_2000;

  card_clk_div uut (.*);

  always #2 clk_i = ~clk_i;

  // behavioural reference model
  int m_div_p = 0, m_en_p = 0, m_src_p = 0;
  int m_div_a = 0, m_en_a = 0, m_src_a = 0;
  int m_cnt = 0, m_tog = 0, m_start = 0, m_wait = 0, m_err = 0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_div_p = 0; m_en_p = 0; m_src_p = 0; m_div_a = 0; m_en_a = 0;
      m_src_a = 0; m_cnt = 0; m_tog = 0; m_start = 0; m_wait = 0; m_err = 0;
    end else begin
      int commit;
      int old_start;
      old_start = m_start;
      commit = (m_start != 0) && !(m_wait != 0 && data_busy_i) && (m_tog == 0);
      if (commit) begin
        m_div_a = m_div_p; m_en_a = m_en_p; m_src_a = m_src_p;
        m_cnt = 0; m_tog = 0; m_start = 0;
      end else if (m_en_a != 0 && m_div_a != 0) begin
        if (m_cnt == m_div_a - 1) begin m_cnt = 0; m_tog = 1 - m_tog; end
        else m_cnt = m_cnt + 1;
      end
      if (wr_en_i) begin
        case (addr_i)
          8'h00: m_div_p = int'(wdata_i[7:0]);
          8'h04: m_en_p  = int'(wdata_i[0]);
          8'h08: m_src_p = int'(wdata_i[1:0]);
          8'h0C: if (wdata_i[31]) begin
                   if (old_start != 0) m_err = 1;
                   else if (wdata_i[21]) begin m_start = 1; m_wait = int'(wdata_i[13]); end
                 end
          8'h10: if (wdata_i[12] && !(m_err != 0 && old_start != 0 && 0)) begin
                   m_err = 0;
                 end
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison, clock high phase
  always @(posedge clk_i) begin
    if (rst_ni && !done) begin
      int exp_clk;
      #1;
      exp_clk = (m_div_a == 0) ? m_en_a : m_tog;
      checks++;
      if (card_clk_o !== exp_clk[0] || card_src_o !== m_src_a[1:0]) begin
        errors++;
        $display("FAIL R2/R6/R11 model t=%0t clk=%b src=%0d expected clk=%0d src=%0d",
                 $time, card_clk_o, card_src_o, exp_clk, m_src_a);
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
    addr_i = a;
    #1;
    check(req, rdata_o, exp);
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // rising-edge spacing in reference cycles
  task automatic period_check(input string req, input int n);
    int t0, t1;
    logic prev;
    int cyc;
    t0 = -1; t1 = -1; cyc = 0;
    prev = card_clk_o;
    while (t1 < 0 && cyc < 2000) begin
      @(posedge clk_i); #1;
      cyc++;
      if (card_clk_o && !prev) begin
        if (t0 < 0) t0 = cyc; else t1 = cyc;
      end
      prev = card_clk_o;
    end
    check(req, t1 - t0, 2 * n);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    #1;
    check("R1 clk", card_clk_o, 0);
    check("R1 src", card_src_o, 0);
    rd_check("R1 cmd", 8'h0C, 0);
    rd_check("R1 raw", 8'h10, 0);

    // R4 pending writes
    wr(8'h00, 32'd3);
    wr(8'h04, 32'd1);
    wr(8'h08, 32'd1);
    rd_check("R4 div readback", 8'h00, 32'd3);
    rd_check("R4 en readback", 8'h04, 32'd1);
    wait_cycles(8);
    check("R4 clk held", card_clk_o, 0);
    check("R4 src held", card_src_o, 0);

    // R5 start handshake
    wr(8'h0C, UPD);
    rd_check("R5 start set", 8'h0C, 32'h8000_0000);
    wait_cycles(1);
    rd_check("R5 start cleared", 8'h0C, 0);
    check("R11 src applied", card_src_o, 1);
    period_check("R2 period N=3", 3);

    // R2 other divisor
    wr(8'h00, 32'd7);
    wr(8'h0C, UPD);
    wait_cycles(20);
    period_check("R2 period N=7", 7);

    // R6 stop mid high phase
    while (card_clk_o !== 1'b1) @(negedge clk_i);
    wr(8'h04, 32'd0);
    wr(8'h0C, UPD);
    rd_check("R6 start held in high phase", 8'h0C, 32'h8000_0000);
    wait_cycles(10);
    rd_check("R6 start cleared", 8'h0C, 0);
    wait_cycles(20);
    check("R6 stopped low", card_clk_o, 0);

    // R3 bypass
    wr(8'h00, 32'd0);
    wr(8'h04, 32'd1);
    wr(8'h0C, UPD);
    wait_cycles(2);
    @(posedge clk_i); #1;
    check("R3 bypass high", card_clk_o, 1);
    @(negedge clk_i); #1;
    check("R3 bypass low", card_clk_o, 0);

    // R9 deferral and R7 lock
    data_busy_i = 1'b1;
    wr(8'h00, 32'd2);
    wr(8'h0C, UPD_WAIT);
    wait_cycles(6);
    rd_check("R9 deferred while busy", 8'h0C, 32'h8000_0000);
    wr(8'h0C, UPD);
    rd_check("R7 lock flag", 8'h10, 32'h0000_1000);
    wait_cycles(3);
    rd_check("R7 second cmd discarded", 8'h0C, 32'h8000_0000);
    wr(8'h10, 32'h0);
    rd_check("R8 zero write keeps", 8'h10, 32'h0000_1000);
    wr(8'h10, 32'h0000_1000);
    rd_check("R8 one write clears", 8'h10, 0);
    data_busy_i = 1'b0;
    wait_cycles(2);
    rd_check("R9 commit after busy", 8'h0C, 0);
    period_check("R2 period N=2", 2);

    // R9 no wait flag: busy ignored
    data_busy_i = 1'b1;
    wr(8'h00, 32'd4);
    wr(8'h0C, UPD);
    wait_cycles(12);
    rd_check("R9 busy ignored", 8'h0C, 0);
    period_check("R9 new period N=4", 4);
    data_busy_i = 1'b0;

    // R10 start without update flag
    wr(8'h08, 32'd2);
    wr(8'h0C, 32'h8000_0000);
    rd_check("R10 not accepted", 8'h0C, 0);
    wait_cycles(12);
    check("R10 src unchanged", card_src_o, 1);
    wr(8'h0C, UPD);
    wait_cycles(12);
    check("R11 src via update", card_src_o, 2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule